// File: doc/BRIEF.md
# Banked General Register File with Console Access Window

This block stores the general registers of a 16-bit processor of the classic minicomputer style. The six working registers R0 to R5 exist twice, as set 0 and set 1. The stack pointer R6 has one copy for each processor mode: kernel, supervisor and user. The program counter R7 has a single copy. A status word held in the block picks the set and the mode for CPU accesses. The block also holds a stack limit word. The CPU side has two combinational read ports and one write port, each addressed by a 3-bit logical register number.

A front panel reaches every physical copy through a fixed window of 22-bit physical addresses. This path does not pass through any address translation. A panel operation is either a load-address, an examine or a deposit. An examine or a deposit acts on the most recently loaded address. Requests use a valid/ready handshake. The block accepts a request only while no response is pending (`con_ready` is low while `rsp_valid` is high). Each accepted request produces exactly one response, in the cycle after acceptance. The response holds its data and error flag until `rsp_ready` is high at a clock edge.

Top module: `gpr_bank_file`

## Requirements
- R1: After reset, every register, the status word and the stack limit read as zero. No response is pending, `con_ready` is high, and the loaded console address is zero, which lies outside the window.
- R2: For logical registers 0 to 5, status word bit 11 selects the copy: 0 gives set 0 and 1 gives set 1. The mode bits have no effect on this choice.
- R3: Logical register 6 selects its copy from status word bits 15:14. The code 00 gives kernel, 01 gives supervisor, and 10 or 11 give user.
- R4: Logical register 7 reads the same single copy under every set and mode.
- R5: When `wr_en` is high at a clock edge, the write port updates the copy that the status word in force before that edge selects. Both read ports show the new value from the next cycle onward.
- R6: Octal addresses 17777700 to 17777717 reach these registers, in order: set-0 R0 to R5, kernel R6, R7, set-1 R0 to R5, supervisor R6, user R6.
- R7: Octal addresses 17777774 and 17777775 reach the stack limit, and 17777776 and 17777777 reach the status word. A status word deposit changes the set and mode used by the CPU ports.
- R8: `con_op` encodes 00 as load-address, 01 as examine and 10 as deposit. A load-address returns data 0 with no error. An examine or a deposit acts on the last loaded address.
- R9: A deposit made while `halted` is low returns an error and changes nothing.
- R10: Any loaded address that reaches nothing under R6 or R7, and `con_op` 11, make an examine return 0 with the error flag set. A deposit to such an address changes no register.
- R11: When a console deposit and a CPU write hit the same register in one cycle, the console value is kept. The same holds for the status word.
- R12: A request is accepted when `con_valid` and `con_ready` are both high. Its response appears in the next cycle and holds its data and error flag until `rsp_ready` is high at an edge. No request is accepted while a response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 3 | Logical register for read port A |
| rd_a_data | output | 16 | Read port A data (combinational) |
| rd_b_idx | input | 3 | Logical register for read port B |
| rd_b_data | output | 16 | Read port B data (combinational) |
| wr_en | input | 1 | CPU register write strobe |
| wr_idx | input | 3 | Logical register to write |
| wr_data | input | 16 | CPU write data |
| psw_we | input | 1 | CPU status word write strobe |
| psw_wdata | input | 16 | CPU status word write data |
| psw_o | output | 16 | Current status word |
| stk_limit_o | output | 16 | Current stack limit word |
| halted | input | 1 | Processor is halted; deposits are allowed |
| con_valid | input | 1 | Console request valid |
| con_ready | output | 1 | Console request can be accepted |
| con_op | input | 2 | Console operation (see R8) |
| con_addr | input | 22 | Physical address for a load-address |
| con_wdata | input | 16 | Deposit data |
| rsp_valid | output | 1 | Console response valid |
| rsp_ready | input | 1 | Console response taken |
| rsp_data | output | 16 | Examine data, zero otherwise |
| rsp_err | output | 1 | Request failed |

## Verification
Assertions check the handshake on every cycle: a response follows each accepted request and stays stable while it is back-pressured. On every cycle they also check that a deposit landed in storage, that an error response carries zero data, and that the status word stays put while the processor runs and the CPU does not write it. Only the bench scenarios can show the banking itself. They walk all eight set and mode combinations against the values deposited at each window address. They also cover the collision between a console deposit and a CPU write, and they confirm that rejected deposits leave all state unchanged.

// File: rtl/gprf_pkg.sv
package gprf_pkg;
  localparam int NPHYS = 16;
  localparam int PIW   = $clog2(NPHYS);
  localparam int LIW   = 3;

  typedef enum logic [1:0] {
    OP_LOAD = 2'b00,
    OP_EXAM = 2'b01,
    OP_DEP  = 2'b10,
    OP_RSVD = 2'b11
  } con_op_e;

  typedef enum logic [1:0] {
    TGT_GPR  = 2'd0,
    TGT_SLIM = 2'd1,
    TGT_PSW  = 2'd2,
    TGT_NONE = 2'd3
  } con_tgt_e;

  localparam int PSW_SET_BIT = 11;
  localparam int PSW_MODE_HI = 15;
  localparam int PSW_MODE_LO = 14;
endpackage

// File: rtl/gprf_cpu_map.sv
module gprf_cpu_map
  import gprf_pkg::*;
(
  input  logic           set_sel,
  input  logic [1:0]     mode,
  input  logic [LIW-1:0] lidx,
  output logic [PIW-1:0] pidx
);
  always_comb begin
    if (lidx == 3'd7) begin
      pidx = 4'd7;
    end else if (lidx == 3'd6) begin
      unique case (mode)
        2'b00:   pidx = 4'd6;
        2'b01:   pidx = 4'd14;
        default: pidx = 4'd15;
      endcase
    end else begin
      pidx = {set_sel, lidx};
    end
  end
endmodule

// File: rtl/gprf_con_decode.sv
module gprf_con_decode
  import gprf_pkg::*;
#(
  parameter int            AW       = 22,
  parameter logic [AW-1:0] WIN_BASE = 22'o17777700
)(
  input  logic [AW-1:0]  addr,
  output con_tgt_e       tgt,
  output logic [PIW-1:0] pidx
);
  logic       in_win;
  logic [5:0] off;

  assign in_win = (addr[AW-1:6] == WIN_BASE[AW-1:6]);
  assign off    = addr[5:0];

  always_comb begin
    pidx = off[PIW-1:0];
    tgt  = TGT_NONE;
    if (in_win) begin
      if (off < 6'(NPHYS))          tgt = TGT_GPR;
      else if (off[5:1] == 5'b11110) tgt = TGT_SLIM;
      else if (off[5:1] == 5'b11111) tgt = TGT_PSW;
    end
  end
endmodule

// File: rtl/gprf_storage.sv
module gprf_storage
  import gprf_pkg::*;
#(
  parameter int DW = 16
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cpu_we,
  input  logic [PIW-1:0]             cpu_idx,
  input  logic [DW-1:0]              cpu_wdata,
  input  logic                       con_we,
  input  logic [PIW-1:0]             con_idx,
  input  logic [DW-1:0]              con_wdata,
  output logic [NPHYS-1:0][DW-1:0]   q
);
  for (genvar i = 0; i < NPHYS; i++) begin : g_reg
    logic con_hit, cpu_hit;
    assign con_hit = con_we && (con_idx == PIW'(i));
    assign cpu_hit = cpu_we && (cpu_idx == PIW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q[i] <= '0;
      else if (con_hit) q[i] <= con_wdata;
      else if (cpu_hit) q[i] <= cpu_wdata;
    end
  end

  // R11: a console deposit always lands, whatever the CPU did in that cycle
  assert_console_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
    con_we |=> (q[$past(con_idx)] == $past(con_wdata)));
endmodule

// File: rtl/gpr_bank_file.sv
module gpr_bank_file
  import gprf_pkg::*;
#(
  parameter int            DW       = 16,
  parameter int            AW       = 22,
  parameter logic [AW-1:0] WIN_BASE = 22'o17777700
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    rd_a_idx,
  output logic [DW-1:0] rd_a_data,
  input  logic [2:0]    rd_b_idx,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [2:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          psw_we,
  input  logic [DW-1:0] psw_wdata,
  output logic [DW-1:0] psw_o,
  output logic [DW-1:0] stk_limit_o,
  input  logic          halted,
  input  logic          con_valid,
  output logic          con_ready,
  input  logic [1:0]    con_op,
  input  logic [AW-1:0] con_addr,
  input  logic [DW-1:0] con_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err
);
  localparam int NPORT = 3;

  logic [DW-1:0]            psw_q, slim_q;
  logic [AW-1:0]            addr_q;
  logic [NPHYS-1:0][DW-1:0] regs;
  logic [NPORT-1:0][LIW-1:0] lidx;
  logic [NPORT-1:0][PIW-1:0] pidx;

  assign lidx = {wr_idx, rd_b_idx, rd_a_idx};

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    gprf_cpu_map u_map (
      .set_sel (psw_q[PSW_SET_BIT]),
      .mode    (psw_q[PSW_MODE_HI:PSW_MODE_LO]),
      .lidx    (lidx[p]),
      .pidx    (pidx[p])
    );
  end

  assign rd_a_data = regs[pidx[0]];
  assign rd_b_data = regs[pidx[1]];

  con_tgt_e       tgt;
  logic [PIW-1:0] con_pidx;

  gprf_con_decode #(.AW(AW), .WIN_BASE(WIN_BASE)) u_dec (
    .addr (addr_q),
    .tgt  (tgt),
    .pidx (con_pidx)
  );

  logic    accept, bad_tgt, dep_ok;
  logic    gpr_dep, slim_dep, psw_dep;
  con_op_e op;
  logic [DW-1:0] exam_val;
  logic [DW-1:0] rsp_data_d;
  logic          rsp_err_d;

  assign op        = con_op_e'(con_op);
  assign con_ready = !rsp_valid;
  assign accept    = con_valid && con_ready;
  assign bad_tgt   = (tgt == TGT_NONE);
  assign dep_ok    = accept && (op == OP_DEP) && !bad_tgt && halted;
  assign gpr_dep   = dep_ok && (tgt == TGT_GPR);
  assign slim_dep  = dep_ok && (tgt == TGT_SLIM);
  assign psw_dep   = dep_ok && (tgt == TGT_PSW);

  always_comb begin
    unique case (tgt)
      TGT_GPR:  exam_val = regs[con_pidx];
      TGT_SLIM: exam_val = slim_q;
      TGT_PSW:  exam_val = psw_q;
      default:  exam_val = '0;
    endcase
  end

  always_comb begin
    rsp_data_d = '0;
    rsp_err_d  = 1'b0;
    unique case (op)
      OP_LOAD: ;
      OP_EXAM: begin
        rsp_err_d  = bad_tgt;
        rsp_data_d = bad_tgt ? '0 : exam_val;
      end
      OP_DEP:  rsp_err_d = bad_tgt || !halted;
      default: rsp_err_d = 1'b1;
    endcase
  end

  gprf_storage #(.DW(DW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_we    (wr_en),
    .cpu_idx   (pidx[2]),
    .cpu_wdata (wr_data),
    .con_we    (gpr_dep),
    .con_idx   (con_pidx),
    .con_wdata (con_wdata),
    .q         (regs)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psw_q     <= '0;
      slim_q    <= '0;
      addr_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      if (psw_dep)     psw_q <= con_wdata;
      else if (psw_we) psw_q <= psw_wdata;
      if (slim_dep)    slim_q <= con_wdata;
      if (accept && op == OP_LOAD) addr_q <= con_addr;
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rsp_data_d;
        rsp_err   <= rsp_err_d;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  assign psw_o       = psw_q;
  assign stk_limit_o = slim_q;

  assert_rsp_follows_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (con_valid && con_ready) |=> rsp_valid);

  assert_rsp_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));

  assert_err_zero_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_data == '0));

  assert_psw_frozen_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && !psw_we) |=> $stable(psw_o));
endmodule

// File: tb/test_gpr_bank_file.sv
`timescale 1ns/1ps
module test_gpr_bank_file;
  localparam logic [21:0] BASE = 22'o17777700;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [2:0] rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic wr_en = 0, psw_we = 0, halted = 0, con_valid = 0, rsp_ready = 1;
  logic [15:0] wr_data = '0, psw_wdata = '0, con_wdata = '0;
  logic [1:0] con_op = '0;
  logic [21:0] con_addr = '0;
  logic [15:0] rd_a_data, rd_b_data, psw_o, stk_limit_o, rsp_data;
  logic con_ready, rsp_valid, rsp_err;

  gpr_bank_file i_gpr_bank_file (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .psw_we(psw_we), .psw_wdata(psw_wdata), .psw_o(psw_o),
    .stk_limit_o(stk_limit_o), .halted(halted),
    .con_valid(con_valid), .con_ready(con_ready), .con_op(con_op),
    .con_addr(con_addr), .con_wdata(con_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_err(rsp_err)
  );

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_gpr [16];
  logic [15:0] m_psw = '0, m_slim = '0, m_rsp_d = '0;
  logic [21:0] m_addr = '0;
  logic m_rsp_v = 0, m_rsp_e = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // logical register + status word -> physical copy (R2, R3, R4)
  function automatic int phys_of(logic [15:0] psw, logic [2:0] idx);
    if (idx == 3'd7) return 7;
    if (idx == 3'd6) begin
      if (psw[15:14] == 2'b00) return 6;
      if (psw[15:14] == 2'b01) return 14;
      return 15;
    end
    return int'(idx) + (psw[11] ? 8 : 0);
  endfunction

  // window address -> physical copy, 16 stack limit, 17 status word, -1 none (R6, R7)
  function automatic int kind_of(logic [21:0] a);
    int off;
    if (a < BASE) return -1;
    off = int'(a - BASE);
    if (off < 16) return off;
    if (off == 'o74 || off == 'o75) return 16;
    if (off == 'o76 || off == 'o77) return 17;
    return -1;
  endfunction

  task automatic model_update();
    int k, cp;
    logic acc;
    logic [15:0] ev;
    k   = kind_of(m_addr);
    cp  = phys_of(m_psw, wr_idx);
    acc = con_valid && !m_rsp_v;
    ev  = (k < 0) ? 16'h0 : (k == 16) ? m_slim : (k == 17) ? m_psw : m_gpr[k];
    if (m_rsp_v && rsp_ready) m_rsp_v = 0;
    if (wr_en)  m_gpr[cp] = wr_data;
    if (psw_we) m_psw = psw_wdata;
    if (acc) begin
      m_rsp_v = 1; m_rsp_d = 0; m_rsp_e = 0;
      case (con_op)
        2'b00: m_addr = con_addr;
        2'b01: begin m_rsp_e = (k < 0); m_rsp_d = ev; end
        2'b10: begin
          m_rsp_e = (k < 0) || !halted;
          if (!m_rsp_e) begin
            if (k == 16) m_slim = con_wdata;
            else if (k == 17) m_psw = con_wdata;
            else m_gpr[k] = con_wdata;
          end
        end
        default: m_rsp_e = 1;
      endcase
    end
  endtask

  task automatic compare_all();
    chk("R5 port A", 32'(rd_a_data), 32'(m_gpr[phys_of(m_psw, rd_a_idx)]));
    chk("R5 port B", 32'(rd_b_data), 32'(m_gpr[phys_of(m_psw, rd_b_idx)]));
    chk("R7 psw", 32'(psw_o), 32'(m_psw));
    chk("R7 stack limit", 32'(stk_limit_o), 32'(m_slim));
    chk("R12 con_ready", 32'(con_ready), 32'(!m_rsp_v));
    chk("R12 rsp_valid", 32'(rsp_valid), 32'(m_rsp_v));
    if (rsp_valid) begin
      chk("R8 rsp_data", 32'(rsp_data), 32'(m_rsp_d));
      chk("R10 rsp_err", 32'(rsp_err), 32'(m_rsp_e));
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    #1;
    compare_all();
    @(negedge clk);
  endtask

  task automatic con_req(input logic [1:0] op, input logic [21:0] a, input logic [15:0] d,
                         input logic exp_err, input logic [15:0] exp_d, input string req);
    con_valid = 1; con_op = op; con_addr = a; con_wdata = d;
    while (!con_ready) tick();
    tick();
    con_valid = 0;
    chk(req, {15'b0, rsp_err, rsp_data}, {15'b0, exp_err, exp_d});
    tick();
  endtask

  function automatic logic [15:0] val(int i);
    return 16'hA000 + 16'(i) * 16'h0111;
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) m_gpr[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rd_a", 32'(rd_a_data), 0);
    chk("R1 psw", 32'(psw_o), 0);
    chk("R1 slim", 32'(stk_limit_o), 0);
    chk("R1 con_ready", 32'(con_ready), 1);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    rst_n = 1;
    @(negedge clk);

    // R8: examine before any load hits address 0, outside the window
    con_req(2'b01, '0, '0, 1'b1, 16'h0, "R8 exam before load");

    halted = 1;
    // R6: deposit a distinct value at every register address
    for (int i = 0; i < 16; i++) begin
      con_req(2'b00, BASE + 22'(i), '0, 1'b0, 16'h0, "R8 load");
      con_req(2'b10, '0, val(i), 1'b0, 16'h0, "R6 deposit");
    end
    con_req(2'b00, BASE + 22'o74, '0, 1'b0, 16'h0, "R8 load");
    con_req(2'b10, '0, 16'h0400, 1'b0, 16'h0, "R7 slim deposit");
    con_req(2'b00, BASE + 22'o75, '0, 1'b0, 16'h0, "R8 load");
    con_req(2'b01, '0, '0, 1'b0, 16'h0400, "R7 slim exam odd byte");

    // R2 R3 R4: every set and mode combination through a status word deposit
    con_req(2'b00, BASE + 22'o76, '0, 1'b0, 16'h0, "R8 load");
    for (int p = 0; p < 8; p++) begin
      logic [15:0] w;
      w = {2'(p), 2'b00, 1'(p >> 2), 11'b0};
      con_req(2'b10, '0, w, 1'b0, 16'h0, "R7 psw deposit");
      chk("R7 psw visible", 32'(psw_o), 32'(w));
      for (int r = 0; r < 6; r++) begin
        rd_a_idx = 3'(r); #0.1;
        chk("R2 bank select", 32'(rd_a_data), 32'(val(r + (p >= 4 ? 8 : 0))));
      end
      rd_a_idx = 3'd6; rd_b_idx = 3'd7; #0.1;
      chk("R3 stack pointer", 32'(rd_a_data),
          32'(val((p % 4) == 0 ? 6 : (p % 4) == 1 ? 14 : 15)));
      chk("R4 program counter", 32'(rd_b_data), 32'(val(7)));
    end

    // R5: CPU writes under set 1 / user, then set 0 / supervisor
    psw_we = 1; psw_wdata = 16'hC800; tick(); psw_we = 0;
    wr_en = 1; wr_idx = 3'd3; wr_data = 16'h1234; tick();
    wr_idx = 3'd6; wr_data = 16'h5678; tick(); wr_en = 0;
    rd_a_idx = 3'd3; rd_b_idx = 3'd6; #0.1;
    chk("R5 set1 r3", 32'(rd_a_data), 32'h1234);
    chk("R5 user sp", 32'(rd_b_data), 32'h5678);
    psw_we = 1; psw_wdata = 16'h4000; tick(); psw_we = 0;
    wr_en = 1; wr_idx = 3'd6; wr_data = 16'h9ABC; tick(); wr_en = 0;
    con_req(2'b00, BASE + 22'o16, '0, 1'b0, 16'h0, "R8 load");
    con_req(2'b01, '0, '0, 1'b0, 16'h9ABC, "R5 supervisor sp via console");
    con_req(2'b00, BASE + 22'o13, '0, 1'b0, 16'h0, "R8 load");
    con_req(2'b01, '0, '0, 1'b0, 16'h1234, "R6 set1 r3 address");
    con_req(2'b00, BASE + 22'o07, '0, 1'b0, 16'h0, "R8 load");
    con_req(2'b01, '0, '0, 1'b0, val(7), "R6 pc address");
    con_req(2'b00, BASE + 22'o77, '0, 1'b0, 16'h0, "R8 load");
    con_req(2'b01, '0, '0, 1'b0, 16'h4000, "R7 psw exam");

    // R10: unused and out-of-window addresses, and the reserved op
    begin
      logic [21:0] bad [4];
      bad[0] = BASE + 22'o20; bad[1] = BASE + 22'o73;
      bad[2] = BASE - 22'd1;  bad[3] = 22'o1000;
      for (int j = 0; j < 4; j++) begin
        con_req(2'b00, bad[j], '0, 1'b0, 16'h0, "R8 load");
        con_req(2'b01, '0, '0, 1'b1, 16'h0, "R10 exam unused");
        con_req(2'b10, '0, 16'hFFFF, 1'b1, 16'h0, "R10 deposit unused");
      end
      con_req(2'b11, '0, '0, 1'b1, 16'h0, "R10 reserved op");
    end

    // R9: deposit while running is refused
    halted = 0;
    con_req(2'b00, BASE + 22'o03, '0, 1'b0, 16'h0, "R8 load");
    con_req(2'b10, '0, 16'hDEAD, 1'b1, 16'h0, "R9 deposit while running");
    con_req(2'b01, '0, '0, 1'b0, val(3), "R9 value unchanged");
    halted = 1;

    // R11: console deposit and CPU write in the same cycle
    psw_we = 1; psw_wdata = 16'h0000; tick(); psw_we = 0;
    con_req(2'b00, BASE, '0, 1'b0, 16'h0, "R8 load");
    con_valid = 1; con_op = 2'b10; con_wdata = 16'h5555;
    wr_en = 1; wr_idx = 3'd0; wr_data = 16'hAAAA;
    tick(); con_valid = 0; wr_en = 0; tick();
    rd_a_idx = 3'd0; #0.1;
    chk("R11 console wins gpr", 32'(rd_a_data), 32'h5555);
    con_req(2'b00, BASE + 22'o76, '0, 1'b0, 16'h0, "R8 load");
    con_valid = 1; con_op = 2'b10; con_wdata = 16'h0800;
    psw_we = 1; psw_wdata = 16'hC000;
    tick(); con_valid = 0; psw_we = 0; tick();
    chk("R11 console wins psw", 32'(psw_o), 32'h0800);

    // R12: back-pressure on the response
    rsp_ready = 0;
    con_valid = 1; con_op = 2'b00; con_addr = BASE + 22'o10;
    tick();
    con_op = 2'b01;
    tick(); tick();
    chk("R12 ready low while pending", 32'(con_ready), 0);
    chk("R12 response held", 32'(rsp_valid), 1);
    rsp_ready = 1;
    tick();
    chk("R12 ready after take", 32'(con_ready), 1);
    tick(); con_valid = 0;
    chk("R12 exam after stall", 32'(rsp_data), 32'(val(8)));
    tick(); tick();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R12 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule